// File: doc/BRIEF.md
# TDM Subchannel Bit Merger

This block builds the outgoing byte of each timeslot on an 8 kHz TDM link from bit fields taken out of several byte FIFOs. When a timeslot index is presented, every enabled FIFO mapped to that slot gives up the low-order bits of its head byte. The number of bits is set by that FIFO's bit count. The block places those bits at the FIFO's programmed start position. Every bit that no FIFO claims comes from a constant mask byte that belongs to the timeslot. Each FIFO is popped at most once per frame, and a frame strobe marks the start of each 125 µs frame.

Two mapping modes exist. In simple mode FIFO `f` always serves timeslot `f`, so the block only masks bits. In channel select mode each FIFO carries its own timeslot number, and several FIFOs can merge their fields into one byte. The receive side runs in transparent mode: a whole incoming timeslot byte is handed, unchanged, to every enabled FIFO mapped to that slot. FIFO storage, framing and register access lie outside the block. All configuration arrives on plain input ports.

Top module: `subch_bitmux`

## Requirements
- R1: While `rstN` is low, `txValid`, `txByte`, `fifoPop`, `rxWrite` and `rxData` are all zero.
- R2: `txValid` is high exactly in the clock after a cycle with `slotValid` high. `txByte` is loaded in that same clock.
- R3: A FIFO contributes the low `bitCnt` bits of its head byte (a count of 0 means 8 bits). They are placed with their bit 0 at output bit `startBit`, where bit 0 is the LSB.
- R4: Every output bit not claimed by a contributing FIFO equals the same bit of the mask byte of the presented timeslot. Slot `s` uses `slotMask[8s+7:8s]`.
- R5: Field bits that would land above output bit 7 (`startBit + count > 8`) are dropped and never wrap.
- R6: With `modeChanSel` = 1, FIFO `f` serves the slot in `fifoSlot[2f+1:2f]`. Fields of several FIFOs on one slot are merged into one byte.
- R7: Where fields overlap within one slot, the FIFO with the higher index sets the overlapping bits.
- R8: With `modeChanSel` = 0, FIFO `f` serves slot `f` only, and `fifoSlot` has no effect.
- R9: A contributing FIFO has its `fifoPop` bit pulsed in the same clock as `txValid`. It contributes and pops at most once per frame. A repeat presentation of its slot in the same frame yields mask bits in its place and no pop.
- R10: `frameStrobe` starts a new frame. A slot presented in the same cycle as the strobe belongs to the new frame.
- R11: One clock after `rxValid`, `rxWrite` has a bit set for each enabled FIFO mapped to `rxIdx`. `rxData` holds the whole received byte, whatever `bitCnt` and `startBit` are.
- R12: A FIFO with its `fifoEn` bit low neither contributes, pops, nor receives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStrobe | input | 1 | Start of a 125 µs frame |
| modeChanSel | input | 1 | 1 = channel select mapping, 0 = simple mapping |
| fifoEn | input | NUM_FIFO | Per-FIFO enable |
| fifoSlot | input | NUM_FIFO*SLOT_W | Timeslot of each FIFO in channel select mode |
| bitCnt | input | NUM_FIFO*3 | Field width per FIFO, 0 = 8 bits |
| startBit | input | NUM_FIFO*3 | Field start position per FIFO |
| slotMask | input | NUM_SLOT*8 | Constant fill byte per timeslot |
| slotValid | input | 1 | Transmit timeslot presented |
| slotIdx | input | SLOT_W | Transmit timeslot index |
| fifoTxData | input | NUM_FIFO*8 | Head byte of each transmit FIFO |
| txValid | output | 1 | Merged byte valid |
| txByte | output | 8 | Merged timeslot byte |
| fifoPop | output | NUM_FIFO | Pop strobe per transmit FIFO |
| rxValid | input | 1 | Receive timeslot byte present |
| rxIdx | input | SLOT_W | Receive timeslot index |
| rxByte | input | 8 | Received timeslot byte |
| rxWrite | output | NUM_FIFO | Write strobe per receive FIFO |
| rxData | output | 8 | Byte written to the receive FIFOs |

## Verification
The assertions check several rules on every cycle:
- the one-clock relation between a presented slot and `txValid`;
- pops that only come with a valid byte;
- no FIFO popping twice inside one frame;
- a slot with no contributor yielding its mask byte exactly;
- received bytes that pass through whole.

Only the bench scenarios can show that the bit fields land where they should. These scenarios cover the field widths and positions, truncation at bit 7, the overlap priority, the two mapping modes and frame restart after a repeated slot, each compared against hand-computed bytes.

// File: rtl/subch_pkg.sv
package subch_pkg;

  typedef struct packed {
    logic txLoad;
    logic rxLoad;
  } subch_strobe_t;

  // Low-order field mask; a count of 0 selects all eight bits.
  function automatic logic [7:0] lowMask(input logic [2:0] cnt);
    logic [8:0] ones;
    ones = (9'd1 << cnt) - 9'd1;
    return (cnt == 3'd0) ? 8'hFF : ones[7:0];
  endfunction

endpackage

// File: rtl/subch_ctrl.sv
module subch_ctrl
  import subch_pkg::*;
#(
  parameter int NUM_FIFO = 4,
  parameter int NUM_SLOT = 4,
  localparam int SLOT_W = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       frameStrobe,
  input  logic                       modeChanSel,
  input  logic [NUM_FIFO-1:0]        fifoEn,
  input  logic [NUM_FIFO*SLOT_W-1:0] fifoSlot,
  input  logic                       slotValid,
  input  logic [SLOT_W-1:0]          slotIdx,
  input  logic                       rxValid,
  input  logic [SLOT_W-1:0]          rxIdx,
  output subch_strobe_t              strobes,
  output logic [NUM_FIFO-1:0]        txHit,
  output logic [NUM_FIFO-1:0]        rxHit
);

  logic [NUM_FIFO-1:0] served;
  logic [NUM_FIFO-1:0] servedNow;
  logic [NUM_FIFO-1:0] mapOk;
  logic [SLOT_W-1:0]   mapSlot [NUM_FIFO];

  // A strobe in the same cycle opens the new frame before the hit test.
  assign servedNow = frameStrobe ? '0 : served;

  for (genvar f = 0; f < NUM_FIFO; f++) begin : g_map
    localparam logic [SLOT_W-1:0] SIMPLE_SLOT = SLOT_W'(f % NUM_SLOT);
    localparam bit SIMPLE_OK = (f < NUM_SLOT);
    assign mapSlot[f] = modeChanSel ? fifoSlot[f*SLOT_W +: SLOT_W] : SIMPLE_SLOT;
    assign mapOk[f]   = fifoEn[f] & (modeChanSel | SIMPLE_OK);
    assign txHit[f]   = slotValid & mapOk[f] & (mapSlot[f] == slotIdx) & ~servedNow[f];
    assign rxHit[f]   = rxValid & mapOk[f] & (mapSlot[f] == rxIdx);
  end

  assign strobes.txLoad = slotValid;
  assign strobes.rxLoad = rxValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) served <= '0;
    else       served <= servedNow | txHit;
  end

endmodule

// File: rtl/subch_datapath.sv
module subch_datapath
  import subch_pkg::*;
#(
  parameter int NUM_FIFO = 4,
  parameter int NUM_SLOT = 4,
  localparam int SLOT_W = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  subch_strobe_t         strobes,
  input  logic [NUM_FIFO-1:0]   txHit,
  input  logic [NUM_FIFO-1:0]   rxHit,
  input  logic [SLOT_W-1:0]     slotIdx,
  input  logic [NUM_FIFO*8-1:0] fifoTxData,
  input  logic [NUM_FIFO*3-1:0] bitCnt,
  input  logic [NUM_FIFO*3-1:0] startBit,
  input  logic [NUM_SLOT*8-1:0] slotMask,
  input  logic [7:0]            rxByte,
  output logic                  txValid,
  output logic [7:0]            txByte,
  output logic [NUM_FIFO-1:0]   fifoPop,
  output logic [NUM_FIFO-1:0]   rxWrite,
  output logic [7:0]            rxData
);

  logic [7:0] merged;

  // Ascending walk: a higher-index FIFO overwrites lower ones on overlap.
  always_comb begin
    logic [7:0]  fm;
    logic [15:0] field;
    logic [15:0] pos;
    fm     = '0;
    field  = '0;
    pos    = '0;
    merged = slotMask[slotIdx*8 +: 8];
    for (int f = 0; f < NUM_FIFO; f++) begin
      if (txHit[f]) begin
        fm     = lowMask(bitCnt[f*3 +: 3]);
        field  = {8'h00, fifoTxData[f*8 +: 8] & fm} << startBit[f*3 +: 3];
        pos    = {8'h00, fm} << startBit[f*3 +: 3];
        merged = (merged & ~pos[7:0]) | field[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txByte  <= '0;
      fifoPop <= '0;
      rxWrite <= '0;
      rxData  <= '0;
    end else begin
      txValid <= strobes.txLoad;
      fifoPop <= txHit;
      rxWrite <= rxHit;
      if (strobes.txLoad) txByte <= merged;
      if (strobes.rxLoad) rxData <= rxByte;
    end
  end

endmodule

// File: rtl/subch_bitmux.sv
module subch_bitmux
  import subch_pkg::*;
#(
  parameter int NUM_FIFO = 4,
  parameter int NUM_SLOT = 4,
  localparam int SLOT_W = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       frameStrobe,
  input  logic                       modeChanSel,
  input  logic [NUM_FIFO-1:0]        fifoEn,
  input  logic [NUM_FIFO*SLOT_W-1:0] fifoSlot,
  input  logic [NUM_FIFO*3-1:0]      bitCnt,
  input  logic [NUM_FIFO*3-1:0]      startBit,
  input  logic [NUM_SLOT*8-1:0]      slotMask,
  input  logic                       slotValid,
  input  logic [SLOT_W-1:0]          slotIdx,
  input  logic [NUM_FIFO*8-1:0]      fifoTxData,
  output logic                       txValid,
  output logic [7:0]                 txByte,
  output logic [NUM_FIFO-1:0]        fifoPop,
  input  logic                       rxValid,
  input  logic [SLOT_W-1:0]          rxIdx,
  input  logic [7:0]                 rxByte,
  output logic [NUM_FIFO-1:0]        rxWrite,
  output logic [7:0]                 rxData
);

  subch_strobe_t       strobes;
  logic [NUM_FIFO-1:0] txHit;
  logic [NUM_FIFO-1:0] rxHit;

  subch_ctrl #(.NUM_FIFO(NUM_FIFO), .NUM_SLOT(NUM_SLOT)) i_ctrl (
    .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe), .modeChanSel(modeChanSel),
    .fifoEn(fifoEn), .fifoSlot(fifoSlot), .slotValid(slotValid), .slotIdx(slotIdx),
    .rxValid(rxValid), .rxIdx(rxIdx), .strobes(strobes), .txHit(txHit), .rxHit(rxHit)
  );

  subch_datapath #(.NUM_FIFO(NUM_FIFO), .NUM_SLOT(NUM_SLOT)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .txHit(txHit), .rxHit(rxHit),
    .slotIdx(slotIdx), .fifoTxData(fifoTxData), .bitCnt(bitCnt), .startBit(startBit),
    .slotMask(slotMask), .rxByte(rxByte), .txValid(txValid), .txByte(txByte),
    .fifoPop(fifoPop), .rxWrite(rxWrite), .rxData(rxData)
  );

endmodule

// File: rtl/subch_bitmux_chk.sv
module subch_bitmux_chk #(
  parameter int NUM_FIFO = 4,
  parameter int NUM_SLOT = 4,
  localparam int SLOT_W = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  frameStrobe,
  input logic [NUM_SLOT*8-1:0] slotMask,
  input logic                  slotValid,
  input logic [SLOT_W-1:0]     slotIdx,
  input logic                  txValid,
  input logic [7:0]            txByte,
  input logic [NUM_FIFO-1:0]   fifoPop,
  input logic                  rxValid,
  input logic [7:0]            rxByte,
  input logic [NUM_FIFO-1:0]   rxWrite,
  input logic [7:0]            rxData
);

  logic                strobeD1;
  logic [NUM_FIFO-1:0] seen;
  logic [7:0]          curMask;

  assign curMask = slotMask[slotIdx*8 +: 8];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeD1 <= 1'b0;
      seen     <= '0;
    end else begin
      strobeD1 <= frameStrobe;
      seen     <= (strobeD1 ? '0 : seen) | fifoPop;
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    slotValid |=> txValid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !slotValid |=> !txValid);
  p_pop_with_byte_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|fifoPop) |-> txValid);
  p_once_per_frame_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobeD1 |-> ((fifoPop & seen) == '0));
  p_mask_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    slotValid |=> (fifoPop != '0) || (txByte == $past(curMask)));
  p_rx_whole_r11: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> rxData == $past(rxByte));
  p_rx_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> rxWrite == '0);

endmodule

bind subch_bitmux subch_bitmux_chk #(.NUM_FIFO(NUM_FIFO), .NUM_SLOT(NUM_SLOT)) i_chk (
  .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe), .slotMask(slotMask),
  .slotValid(slotValid), .slotIdx(slotIdx), .txValid(txValid), .txByte(txByte),
  .fifoPop(fifoPop), .rxValid(rxValid), .rxByte(rxByte), .rxWrite(rxWrite),
  .rxData(rxData)
);

// File: tb/test_subch_bitmux.sv
module test_subch_bitmux;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] FIFO_DATA = 32'h0FF0_3CA5;

  typedef struct packed {
    logic        mode;
    logic [3:0]  en;
    logic [7:0]  map;
    logic [11:0] cnt;
    logic [11:0] start;
    logic [7:0]  mask;
    logic [1:0]  slot;
    logic [7:0]  expByte;
    logic [3:0]  expPop;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 4'b0001, 8'h00, 12'h000, 12'h000, 8'h00, 2'd0, 8'hA5, 4'b0001},
    '{1'b0, 4'b0001, 8'h00, 12'h003, 12'h002, 8'hFF, 2'd0, 8'hF7, 4'b0001},
    '{1'b0, 4'b0010, 8'h00, 12'h020, 12'h028, 8'hFF, 2'd1, 8'h9F, 4'b0010},
    '{1'b1, 4'b0111, 8'h2A, 12'h0DA, 12'h150, 8'hAA, 2'd2, 8'h11, 4'b0111},
    '{1'b1, 4'b0011, 8'h0F, 12'h020, 12'h010, 8'h00, 2'd3, 8'hB1, 4'b0011},
    '{1'b0, 4'b1111, 8'h00, 12'h000, 12'h000, 8'h00, 2'd3, 8'h0F, 4'b1000},
    '{1'b1, 4'b0000, 8'h55, 12'h000, 12'h000, 8'h5A, 2'd1, 8'h5A, 4'b0000},
    '{1'b0, 4'b0100, 8'h00, 12'h040, 12'h1C0, 8'hFF, 2'd2, 8'h7F, 4'b0100}
  };
  localparam string VTAG [NVEC] = '{"R3", "R4", "R5", "R6", "R7", "R8", "R12", "R8"};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStrobe = 1'b0;
  logic        modeChanSel = 1'b0;
  logic [3:0]  fifoEn = '0;
  logic [7:0]  fifoSlot = '0;
  logic [11:0] bitCnt = '0;
  logic [11:0] startBit = '0;
  logic [31:0] slotMask = '0;
  logic        slotValid = 1'b0;
  logic [1:0]  slotIdx = '0;
  logic [31:0] fifoTxData = FIFO_DATA;
  logic        txValid;
  logic [7:0]  txByte;
  logic [3:0]  fifoPop;
  logic        rxValid = 1'b0;
  logic [1:0]  rxIdx = '0;
  logic [7:0]  rxByte = '0;
  logic [3:0]  rxWrite;
  logic [7:0]  rxData;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subch_bitmux #(.NUM_FIFO(4), .NUM_SLOT(4)) i_subch_bitmux (
    .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe), .modeChanSel(modeChanSel),
    .fifoEn(fifoEn), .fifoSlot(fifoSlot), .bitCnt(bitCnt), .startBit(startBit),
    .slotMask(slotMask), .slotValid(slotValid), .slotIdx(slotIdx),
    .fifoTxData(fifoTxData), .txValid(txValid), .txByte(txByte), .fifoPop(fifoPop),
    .rxValid(rxValid), .rxIdx(rxIdx), .rxByte(rxByte), .rxWrite(rxWrite), .rxData(rxData)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Present one transmit slot at a negedge; outputs are read one clock later.
  task automatic present(input logic strobe, input logic [1:0] slot);
    @(negedge clk);
    frameStrobe = strobe;
    slotValid   = 1'b1;
    slotIdx     = slot;
    @(negedge clk);
    frameStrobe = 1'b0;
    slotValid   = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1", "txValid", 32'(txValid), 0);
    check("R1", "txByte", 32'(txByte), 0);
    check("R1", "fifoPop", 32'(fifoPop), 0);
    check("R1", "rxWrite", 32'(rxWrite), 0);
    check("R1", "rxData", 32'(rxData), 0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      modeChanSel = VECS[i].mode;
      fifoEn      = VECS[i].en;
      fifoSlot    = VECS[i].map;
      bitCnt      = VECS[i].cnt;
      startBit    = VECS[i].start;
      slotMask    = {4{VECS[i].mask}};
      present(1'b1, VECS[i].slot);
      check(VTAG[i], "txByte", 32'(txByte), 32'(VECS[i].expByte));
      check(VTAG[i], "fifoPop", 32'(fifoPop), 32'(VECS[i].expPop));
      check("R2", "txValid", 32'(txValid), 1);
    end

    // R2: no slot presented -> no valid
    @(negedge clk);
    check("R2", "txValid idle", 32'(txValid), 0);

    // R9 / R10: repeat within a frame, then a new frame
    modeChanSel = 1'b0; fifoEn = 4'b0001; bitCnt = '0; startBit = '0;
    slotMask = {4{8'h33}};
    present(1'b1, 2'd0);
    check("R9", "first txByte", 32'(txByte), 32'hA5);
    check("R9", "first pop", 32'(fifoPop), 32'h1);
    present(1'b0, 2'd0);
    check("R9", "repeat txByte", 32'(txByte), 32'h33);
    check("R9", "repeat pop", 32'(fifoPop), 0);
    present(1'b1, 2'd0);
    check("R10", "new frame txByte", 32'(txByte), 32'hA5);
    check("R10", "new frame pop", 32'(fifoPop), 32'h1);

    // R11: receive side, channel select, fields ignored
    @(negedge clk);
    modeChanSel = 1'b1; fifoEn = 4'b0101; fifoSlot = 8'h11;
    bitCnt = 12'h0DB; startBit = 12'h124;
    rxValid = 1'b1; rxIdx = 2'd1; rxByte = 8'hC3;
    @(negedge clk);
    rxValid = 1'b0;
    check("R11", "rxWrite chansel", 32'(rxWrite), 32'h5);
    check("R11", "rxData chansel", 32'(rxData), 32'hC3);
    // R11 / R8: simple mode receive
    modeChanSel = 1'b0; fifoEn = 4'b1111;
    rxValid = 1'b1; rxIdx = 2'd2; rxByte = 8'h7E;
    @(negedge clk);
    rxValid = 1'b0;
    check("R11", "rxWrite simple", 32'(rxWrite), 32'h4);
    check("R11", "rxData simple", 32'(rxData), 32'h7E);
    @(negedge clk);
    check("R11", "rxWrite idle", 32'(rxWrite), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule